// File: doc/BRIEF.md
# Linked-List DMA Channel Engine

This block is the transfer sequencer of a multi-channel DMA controller. The channel registers (source address, destination address, link pointer, control word and configuration word) are held in a register file next to it. The engine reads that register file through flat input buses and writes results back through a single update strobe. A kick pulse starts a scan. The engine walks the channels from index 0 upward and tests each one for a live, requested transfer with elements left. For each such channel it moves one element through a valid/ready memory master, then posts the new addresses and count.

The engine looks at the same channel again after every element, so a channel drains completely before the scan moves on. When a channel's count reaches zero and its link pointer is nonzero, the engine fetches a four-word descriptor from memory and posts it as the channel's next transfer. This lets software build chains of transfers that run without further intervention. Peripheral request lines gate a channel according to its flow setting. A kick that arrives while a scan is under way is remembered and causes a fresh full scan once the current one ends.

Top module: `dma_ll_engine`

## Requirements
- R1: After reset, and whenever `glb_en` is 0 when `kick` is pulsed, the engine makes no memory access and no register update.
- R2: A channel is serviced only when configuration bit 0 (enable) is 1 and configuration bit 18 (halt) is 0.
- R3: The flow field is configuration bits 13:11. The source peripheral number is bits 5:1 and the destination peripheral number is bits 10:6, each an index into `req`. Flow 0 needs no request. Flow 1 needs the destination's request line, flow 2 the source's, and flow 3 both. Request lines are sampled when each element is considered.
- R4: An enabled, unhalted channel with flow 4 to 7 gets no transfer, and the engine pulses `flow_err` for one cycle when it passes that channel.
- R5: The remaining count is control bits 11:0, and a channel with count 0 is skipped. Each element is one read of 2^control[20:18] bytes at the source address, then one write of 2^control[23:21] bytes at the destination address carrying the read word. The posted count is one less.
- R6: The source address advances by the source width when control bit 26 is 1, and the destination address advances by the destination width when control bit 27 is 1. Otherwise the address is kept.
- R7: When the count reaches 0 with a nonzero link pointer, the engine makes four word reads at link+0, link+4, link+12 and link+8, in that order. These give the new source, destination, control and link pointer, which are then posted together.
- R8: When the count reaches 0 with a zero link pointer, the update clears the channel's enable bit (`upd_clr_en` = 1, posted count 0).
- R9: At each completion, `tc_set` pulses the channel's bit exactly when bit 31 of the control word that is current after completion is 1. For a reload, that is the control word just fetched.
- R10: After an element, the same channel is examined again before any higher channel, so the channels are drained strictly in index order.
- R11: A memory request holds its address, direction and data until `mem_ready` is seen.
- R12: A `kick` received while a scan is in progress causes one more complete scan from channel 0 after the current scan ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global transfer enable |
| kick | input | 1 | Start-scan pulse |
| req | input | 32 | Peripheral request lines |
| chan_src | input | NCH*AW | Source address of every channel |
| chan_dst | input | NCH*AW | Destination address of every channel |
| chan_lli | input | NCH*AW | Link pointer of every channel |
| chan_ctrl | input | NCH*32 | Control word of every channel |
| chan_conf | input | NCH*32 | Configuration word of every channel |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_size | output | 3 | log2 of access bytes |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts / completes the access |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` on a read |
| upd_valid | output | 1 | Register update strobe |
| upd_chan | output | CHW | Channel being updated |
| upd_src | output | AW | New source address |
| upd_dst | output | AW | New destination address |
| upd_lli | output | AW | New link pointer |
| upd_ctrl | output | 32 | New control word |
| upd_clr_en | output | 1 | Clear the channel's enable bit |
| tc_set | output | NCH | Per-channel terminal-count set pulse |
| flow_err | output | 1 | Unsupported flow setting seen |
| busy | output | 1 | A scan is in progress |

## Verification
The bench builds the engine with four channels and 32-bit addresses. With four channels the last-channel wrap is reached often: the scan end, the rescan decision and the return to channel 0 are all exercised. A late kick can also enable a low channel while a higher one is still draining. The memory answers only on every third cycle, or every ninth in the stall test, so every request waits across several cycles. This puts each element, each descriptor fetch and each in-order drain of two channels under the scoreboard's order and data comparison.

// File: rtl/dma_ll_pkg.sv
package dma_ll_pkg;
  localparam int WORD     = 32;
  localparam int PERIPH_W = 5;
  localparam int REQ_N    = 1 << PERIPH_W;

  // configuration word fields
  localparam int CF_EN    = 0;
  localparam int CF_SRCP  = 1;
  localparam int CF_DSTP  = 6;
  localparam int CF_FLOW  = 11;
  localparam int CF_HALT  = 18;

  // control word fields
  localparam int CT_CNT_W = 12;
  localparam int CT_SW    = 18;
  localparam int CT_DW    = 21;
  localparam int CT_SINC  = 26;
  localparam int CT_DINC  = 27;
  localparam int CT_TC    = 31;

  typedef enum logic [2:0] {
    ST_IDLE, ST_EVAL, ST_RD, ST_WR, ST_LINK, ST_SETTLE
  } eng_st_t;

  // descriptor word order: src, dst, ctrl, then link pointer last
  function automatic logic [7:0] link_offset(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'd0;
      2'd1:    return 8'd4;
      2'd2:    return 8'd12;
      default: return 8'd8;
    endcase
  endfunction
endpackage

// File: rtl/dma_ll_eval.sv
module dma_ll_eval
  import dma_ll_pkg::*;
(
  input  logic [WORD-1:0]     conf,
  input  logic [CT_CNT_W-1:0] cnt,
  input  logic [REQ_N-1:0]    req,
  output logic                go,
  output logic                bad_flow
);
  logic                live;
  logic [2:0]          flow;
  logic [PERIPH_W-1:0] sp, dp;
  logic                req_ok;
  logic                unused_conf;

  assign unused_conf = ^{conf[WORD-1:CF_HALT+1], conf[CF_HALT-1:CF_FLOW+3]};

  always_comb begin
    live = conf[CF_EN] & ~conf[CF_HALT];
    flow = conf[CF_FLOW +: 3];
    sp   = conf[CF_SRCP +: PERIPH_W];
    dp   = conf[CF_DSTP +: PERIPH_W];
    case (flow)
      3'd0:    req_ok = 1'b1;
      3'd1:    req_ok = req[dp];
      3'd2:    req_ok = req[sp];
      3'd3:    req_ok = req[sp] & req[dp];
      default: req_ok = 1'b0;
    endcase
    go       = live & ~flow[2] & req_ok & (cnt != '0);
    bad_flow = live & flow[2];
  end
endmodule

// File: rtl/dma_ll_rescan.sv
module dma_ll_rescan (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  input  logic active,
  input  logic take,
  output logic pend
);
  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= (pend & ~take) | (kick & active);
  end
endmodule

// File: rtl/dma_ll_engine.sv
module dma_ll_engine
  import dma_ll_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 32,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                glb_en,
  input  logic                kick,
  input  logic [REQ_N-1:0]    req,
  input  logic [NCH*AW-1:0]   chan_src,
  input  logic [NCH*AW-1:0]   chan_dst,
  input  logic [NCH*AW-1:0]   chan_lli,
  input  logic [NCH*WORD-1:0] chan_ctrl,
  input  logic [NCH*WORD-1:0] chan_conf,
  output logic                mem_valid,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [2:0]          mem_size,
  output logic [WORD-1:0]     mem_wdata,
  input  logic                mem_ready,
  input  logic [WORD-1:0]     mem_rdata,
  output logic                upd_valid,
  output logic [CHW-1:0]      upd_chan,
  output logic [AW-1:0]       upd_src,
  output logic [AW-1:0]       upd_dst,
  output logic [AW-1:0]       upd_lli,
  output logic [WORD-1:0]     upd_ctrl,
  output logic                upd_clr_en,
  output logic [NCH-1:0]      tc_set,
  output logic                flow_err,
  output logic                busy
);
  localparam logic [CHW-1:0] LAST = CHW'(NCH - 1);

  eng_st_t               state;
  logic [CHW-1:0]        ch;
  logic [AW-1:0]         w_src, w_dst, w_lli;
  logic [WORD-1:0]       w_ctrl, xfer;
  logic [1:0]            link_idx;

  logic [AW-1:0]         cur_src, cur_dst, cur_lli;
  logic [WORD-1:0]       cur_ctrl, cur_conf;
  logic                  go, bad_flow, pend, take;
  logic [AW-1:0]         s_step, d_step, nxt_src, nxt_dst;
  logic [CT_CNT_W-1:0]   cnt_next;
  logic                  at_end;

  always_comb begin
    cur_src  = chan_src [int'(ch)*AW   +: AW];
    cur_dst  = chan_dst [int'(ch)*AW   +: AW];
    cur_lli  = chan_lli [int'(ch)*AW   +: AW];
    cur_ctrl = chan_ctrl[int'(ch)*WORD +: WORD];
    cur_conf = chan_conf[int'(ch)*WORD +: WORD];
  end

  dma_ll_eval u_eval (
    .conf     (cur_conf),
    .cnt      (cur_ctrl[CT_CNT_W-1:0]),
    .req      (req),
    .go       (go),
    .bad_flow (bad_flow)
  );

  assign at_end = (state == ST_EVAL) && !(glb_en && go) && (ch == LAST);
  assign take   = at_end && (pend || kick);

  dma_ll_rescan u_rescan (
    .clk    (clk),
    .rst    (rst),
    .kick   (kick),
    .active (state != ST_IDLE),
    .take   (take),
    .pend   (pend)
  );

  always_comb begin
    s_step   = w_ctrl[CT_SINC] ? (AW'(1) << w_ctrl[CT_SW +: 3]) : '0;
    d_step   = w_ctrl[CT_DINC] ? (AW'(1) << w_ctrl[CT_DW +: 3]) : '0;
    nxt_src  = w_src + s_step;
    nxt_dst  = w_dst + d_step;
    cnt_next = w_ctrl[CT_CNT_W-1:0] - CT_CNT_W'(1);
  end

  // memory master driven from registered state only
  always_comb begin
    mem_valid = (state == ST_RD) || (state == ST_WR) || (state == ST_LINK);
    mem_we    = (state == ST_WR);
    mem_wdata = xfer;
    case (state)
      ST_WR:   begin mem_addr = w_dst; mem_size = w_ctrl[CT_DW +: 3]; end
      ST_LINK: begin mem_addr = w_lli + AW'(link_offset(link_idx)); mem_size = 3'd2; end
      default: begin mem_addr = w_src; mem_size = w_ctrl[CT_SW +: 3]; end
    endcase
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      ch         <= '0;
      w_src      <= '0;
      w_dst      <= '0;
      w_lli      <= '0;
      w_ctrl     <= '0;
      xfer       <= '0;
      link_idx   <= '0;
      upd_valid  <= 1'b0;
      upd_chan   <= '0;
      upd_src    <= '0;
      upd_dst    <= '0;
      upd_lli    <= '0;
      upd_ctrl   <= '0;
      upd_clr_en <= 1'b0;
      tc_set     <= '0;
      flow_err   <= 1'b0;
    end else begin
      upd_valid <= 1'b0;
      tc_set    <= '0;
      flow_err  <= 1'b0;
      case (state)
        ST_IDLE: if (kick && glb_en) begin
          ch    <= '0;
          state <= ST_EVAL;
        end
        ST_EVAL: begin
          if (glb_en && go) begin
            w_src  <= cur_src;
            w_dst  <= cur_dst;
            w_lli  <= cur_lli;
            w_ctrl <= cur_ctrl;
            state  <= ST_RD;
          end else begin
            flow_err <= glb_en & bad_flow;
            if (ch == LAST) begin
              if (pend || kick) ch    <= '0;
              else              state <= ST_IDLE;
            end else begin
              ch <= ch + CHW'(1);
            end
          end
        end
        ST_RD: if (mem_ready) begin
          xfer  <= mem_rdata;
          state <= ST_WR;
        end
        ST_WR: if (mem_ready) begin
          w_src <= nxt_src;
          w_dst <= nxt_dst;
          w_ctrl[CT_CNT_W-1:0] <= cnt_next;
          if (cnt_next == '0 && w_lli != '0) begin
            link_idx <= 2'd0;
            state    <= ST_LINK;
          end else begin
            upd_valid  <= 1'b1;
            upd_chan   <= ch;
            upd_src    <= nxt_src;
            upd_dst    <= nxt_dst;
            upd_lli    <= w_lli;
            upd_ctrl   <= {w_ctrl[WORD-1:CT_CNT_W], cnt_next};
            upd_clr_en <= (cnt_next == '0);
            tc_set     <= (cnt_next == '0 && w_ctrl[CT_TC]) ? (NCH'(1) << ch) : '0;
            state      <= ST_SETTLE;
          end
        end
        ST_LINK: if (mem_ready) begin
          link_idx <= link_idx + 2'd1;
          case (link_idx)
            2'd0: w_src  <= mem_rdata[AW-1:0];
            2'd1: w_dst  <= mem_rdata[AW-1:0];
            2'd2: w_ctrl <= mem_rdata;
            default: begin
              upd_valid  <= 1'b1;
              upd_chan   <= ch;
              upd_src    <= w_src;
              upd_dst    <= w_dst;
              upd_lli    <= mem_rdata[AW-1:0];
              upd_ctrl   <= w_ctrl;
              upd_clr_en <= 1'b0;
              tc_set     <= w_ctrl[CT_TC] ? (NCH'(1) << ch) : '0;
              state      <= ST_SETTLE;
            end
          endcase
        end
        ST_SETTLE: state <= ST_EVAL;
        default:   state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_ll_engine_chk.sv
module dma_ll_engine_chk
  import dma_ll_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            mem_valid,
  input logic            mem_ready,
  input logic            mem_we,
  input logic [AW-1:0]   mem_addr,
  input logic [WORD-1:0] mem_wdata,
  input logic            upd_valid,
  input logic            upd_clr_en,
  input logic [WORD-1:0] upd_ctrl,
  input logic [NCH-1:0]  tc_set,
  input logic            flow_err
);
  logic unused_ctrl;
  assign unused_ctrl = ^upd_ctrl[WORD-1:CT_CNT_W];

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_tc_single_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tc_set));

  assert_tc_with_update_R9: assert property (@(posedge clk) disable iff (rst)
    (|tc_set) |-> upd_valid);

  assert_clear_at_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_clr_en) |-> (upd_ctrl[CT_CNT_W-1:0] == '0));

  assert_reexamine_gap_R10: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> (!upd_valid && !mem_valid));

  assert_bad_flow_idle_R4: assert property (@(posedge clk) disable iff (rst)
    flow_err |-> !mem_valid);
endmodule

bind dma_ll_engine dma_ll_engine_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .upd_valid  (upd_valid),
  .upd_clr_en (upd_clr_en),
  .upd_ctrl   (upd_ctrl),
  .tc_set     (tc_set),
  .flow_err   (flow_err)
);

// File: tb/sim_dma_ll_engine.sv
module sim_dma_ll_engine;
  import dma_ll_pkg::*;
  localparam int NCH = 4;
  localparam int AW  = 32;
  localparam int CHW = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                rst, glb_en, kick;
  logic [REQ_N-1:0]    req;
  logic [NCH*AW-1:0]   chan_src, chan_dst, chan_lli;
  logic [NCH*WORD-1:0] chan_ctrl, chan_conf;
  logic                mem_valid, mem_we, mem_ready;
  logic [AW-1:0]       mem_addr;
  logic [2:0]          mem_size;
  logic [WORD-1:0]     mem_wdata, mem_rdata;
  logic                upd_valid, upd_clr_en, flow_err, busy;
  logic [CHW-1:0]      upd_chan;
  logic [AW-1:0]       upd_src, upd_dst, upd_lli;
  logic [WORD-1:0]     upd_ctrl;
  logic [NCH-1:0]      tc_set;

  logic [31:0] r_src [NCH];
  logic [31:0] r_dst [NCH];
  logic [31:0] r_lli [NCH];
  logic [31:0] r_ctrl[NCH];
  logic [31:0] r_conf[NCH];
  logic [31:0] mem [0:255];

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [2:0]  size;
    logic [31:0] data;
  } acc_t;
  acc_t q[$];

  int checks = 0, errors = 0, cyc = 0, rdy_div = 3, hs_cnt = 0, err_cnt = 0;
  int tc_cnt[NCH];
  string cur_req = "R1";

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      chan_src [i*AW +: AW]     = r_src[i];
      chan_dst [i*AW +: AW]     = r_dst[i];
      chan_lli [i*AW +: AW]     = r_lli[i];
      chan_ctrl[i*WORD +: WORD] = r_ctrl[i];
      chan_conf[i*WORD +: WORD] = r_conf[i];
    end
  end

  dma_ll_engine #(.NCH(NCH), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .glb_en(glb_en), .kick(kick), .req(req),
    .chan_src(chan_src), .chan_dst(chan_dst), .chan_lli(chan_lli),
    .chan_ctrl(chan_ctrl), .chan_conf(chan_conf),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .upd_valid(upd_valid), .upd_chan(upd_chan), .upd_src(upd_src), .upd_dst(upd_dst),
    .upd_lli(upd_lli), .upd_ctrl(upd_ctrl), .upd_clr_en(upd_clr_en),
    .tc_set(tc_set), .flow_err(flow_err), .busy(busy)
  );

  function automatic logic [31:0] mkconf(input logic en, input logic halt, input int flow,
                                         input int sp, input int dp);
    return (32'(halt) << 18) | (32'(flow) << 11) | (32'(dp) << 6) | (32'(sp) << 1) | 32'(en);
  endfunction

  function automatic logic [31:0] mkctrl(input logic tc, input logic di, input logic si,
                                         input int dw, input int sw, input int cnt);
    return (32'(tc) << 31) | (32'(di) << 27) | (32'(si) << 26) | (32'(dw) << 21)
         | (32'(sw) << 18) | 32'(cnt);
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic exp_rd(input logic [31:0] a, input logic [2:0] sz);
    q.push_back('{we: 1'b0, addr: a, size: sz, data: 32'h0});
  endtask

  task automatic exp_elem(input logic [31:0] s, input logic [2:0] ssz,
                          input logic [31:0] d, input logic [2:0] dsz);
    exp_rd(s, ssz);
    q.push_back('{we: 1'b1, addr: d, size: dsz, data: mem[s[9:2]]});
  endtask

  task automatic pulse_kick();
    @(negedge clk) kick = 1'b1;
    @(negedge clk) kick = 1'b0;
  endtask

  task automatic wait_done();
    repeat (4) @(negedge clk);
    for (int i = 0; i < 4000; i++) begin
      if (!busy && q.size() == 0) break;
      @(negedge clk);
    end
    check(q.size() == 0 && !busy, {cur_req, " scoreboard drained"}, 32'(q.size()), 0);
  endtask

  task automatic clear_chans();
    @(negedge clk);
    for (int i = 0; i < NCH; i++) begin
      r_conf[i] = '0; r_ctrl[i] = '0; r_lli[i] = '0; r_src[i] = '0; r_dst[i] = '0;
    end
  endtask

  // scoreboard monitor, memory model and register file model
  initial begin
    acc_t e;
    mem_ready = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_ready = ((cyc % rdy_div) == 0);
      mem_rdata = mem[mem_addr[9:2]];
      if (!rst) begin
        if (upd_valid) begin
          r_src[upd_chan]  = upd_src;
          r_dst[upd_chan]  = upd_dst;
          r_lli[upd_chan]  = upd_lli;
          r_ctrl[upd_chan] = upd_ctrl;
          if (upd_clr_en) r_conf[upd_chan][0] = 1'b0;
        end
        for (int i = 0; i < NCH; i++) if (tc_set[i]) tc_cnt[i]++;
        if (flow_err) err_cnt++;
        if (mem_valid && mem_ready) begin
          hs_cnt++;
          checks++;
          if (q.size() == 0) begin
            errors++;
            $display("FAIL %s unexpected access actual=%h expected=none", cur_req, mem_addr);
          end else begin
            e = q.pop_front();
            if (mem_we !== e.we || mem_addr !== e.addr || mem_size !== e.size
                || (e.we && mem_wdata !== e.data)) begin
              errors++;
              $display("FAIL %s access actual we=%0b addr=%h size=%0d data=%h expected we=%0b addr=%h size=%0d data=%h",
                       cur_req, mem_we, mem_addr, mem_size, mem_wdata, e.we, e.addr, e.size, e.data);
            end
          end
          if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=finish", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hs0, tc0;
    rst = 1'b1; glb_en = 1'b0; kick = 1'b0; req = '0;
    for (int i = 0; i < NCH; i++) begin
      r_src[i] = '0; r_dst[i] = '0; r_lli[i] = '0; r_ctrl[i] = '0; r_conf[i] = '0; tc_cnt[i] = 0;
    end
    for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 + 32'(i);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!mem_valid && !upd_valid && !busy && tc_set == '0, "R1 reset outputs",
          {mem_valid, upd_valid, busy, 29'(tc_set)}, 0);
    rst = 1'b0;

    // R1: global enable off
    cur_req = "R1";
    @(negedge clk);
    r_src[0] = 32'h0; r_dst[0] = 32'h100;
    r_ctrl[0] = mkctrl(1, 1, 1, 2, 2, 2);
    r_conf[0] = mkconf(1, 0, 0, 0, 0);
    hs0 = hs_cnt;
    pulse_kick();
    repeat (40) @(negedge clk);
    check(hs_cnt == hs0, "R1 no access when disabled", 32'(hs_cnt - hs0), 0);
    check(r_ctrl[0][11:0] == 12'd2, "R1 count untouched", r_ctrl[0], 2);

    // R5 R6 R8 R9: word elements, both addresses advance, no link
    cur_req = "R5";
    glb_en = 1'b1;
    @(negedge clk);
    r_ctrl[0] = mkctrl(1, 1, 1, 2, 2, 3);
    for (int i = 0; i < 3; i++) exp_elem(32'(4*i), 3'd2, 32'h100 + 32'(4*i), 3'd2);
    tc0 = tc_cnt[0];
    pulse_kick();
    wait_done();
    check(r_ctrl[0][11:0] == 0, "R5 count reaches zero", r_ctrl[0], 0);
    check(r_src[0] == 32'hC && r_dst[0] == 32'h10C, "R6 addresses advanced", r_src[0] ^ r_dst[0], 32'h100);
    check(r_conf[0][0] == 1'b0, "R8 enable cleared", r_conf[0], 0);
    check(tc_cnt[0] == tc0 + 1, "R9 terminal count set", 32'(tc_cnt[0]), 32'(tc0 + 1));

    // R6: byte reads, halfword writes, only source advances, no tc
    cur_req = "R6";
    @(negedge clk);
    r_src[0] = 32'h20; r_dst[0] = 32'h140;
    r_ctrl[0] = mkctrl(0, 0, 1, 1, 0, 2);
    r_conf[0] = mkconf(1, 0, 0, 0, 0);
    exp_elem(32'h20, 3'd0, 32'h140, 3'd1);
    exp_elem(32'h21, 3'd0, 32'h140, 3'd1);
    tc0 = tc_cnt[0];
    pulse_kick();
    wait_done();
    check(r_src[0] == 32'h22, "R6 source step by byte", r_src[0], 32'h22);
    check(r_dst[0] == 32'h140, "R6 destination held", r_dst[0], 32'h140);
    check(tc_cnt[0] == tc0, "R9 no tc without bit 31", 32'(tc_cnt[0]), 32'(tc0));

    // R2: halted and disabled channels ignored
    cur_req = "R2";
    clear_chans();
    r_ctrl[1] = mkctrl(0, 1, 1, 2, 2, 2); r_conf[1] = mkconf(1, 1, 0, 0, 0);
    r_ctrl[2] = mkctrl(0, 1, 1, 2, 2, 2); r_conf[2] = mkconf(0, 0, 0, 0, 0);
    hs0 = hs_cnt;
    pulse_kick();
    wait_done();
    check(hs_cnt == hs0, "R2 no access", 32'(hs_cnt - hs0), 0);
    check(r_ctrl[1][11:0] == 2 && r_ctrl[2][11:0] == 2, "R2 counts kept",
          {r_ctrl[1][15:0], r_ctrl[2][15:0]}, 32'h0002_0002);

    // R3: request gating
    cur_req = "R3";
    clear_chans();
    r_src[1] = 32'h40; r_dst[1] = 32'h180;
    r_ctrl[1] = mkctrl(0, 1, 1, 2, 2, 1); r_conf[1] = mkconf(1, 0, 1, 3, 5);
    req = 32'(1) << 3;
    hs0 = hs_cnt;
    pulse_kick();
    wait_done();
    check(hs_cnt == hs0 && r_ctrl[1][11:0] == 1, "R3 flow1 waits for dest request", 32'(hs_cnt - hs0), 0);
    req = 32'(1) << 5;
    exp_elem(32'h40, 3'd2, 32'h180, 3'd2);
    pulse_kick();
    wait_done();
    check(r_ctrl[1][11:0] == 0, "R3 flow1 runs on dest request", r_ctrl[1], 0);
    r_src[2] = 32'h50; r_dst[2] = 32'h1A0;
    r_ctrl[2] = mkctrl(0, 1, 1, 2, 2, 1); r_conf[2] = mkconf(1, 0, 3, 7, 9);
    req = 32'(1) << 7;
    hs0 = hs_cnt;
    pulse_kick();
    wait_done();
    check(hs_cnt == hs0, "R3 flow3 needs both requests", 32'(hs_cnt - hs0), 0);
    req = (32'(1) << 7) | (32'(1) << 9);
    exp_elem(32'h50, 3'd2, 32'h1A0, 3'd2);
    pulse_kick();
    wait_done();
    check(r_ctrl[2][11:0] == 0, "R3 flow3 runs with both", r_ctrl[2], 0);
    r_src[3] = 32'h58; r_dst[3] = 32'h1B0;
    r_ctrl[3] = mkctrl(0, 1, 1, 2, 2, 1); r_conf[3] = mkconf(1, 0, 2, 12, 1);
    req = 32'(1) << 12;
    exp_elem(32'h58, 3'd2, 32'h1B0, 3'd2);
    pulse_kick();
    wait_done();
    check(r_ctrl[3][11:0] == 0, "R3 flow2 runs on source request", r_ctrl[3], 0);
    req = '0;

    // R4: unsupported flow
    cur_req = "R4";
    clear_chans();
    r_ctrl[0] = mkctrl(0, 1, 1, 2, 2, 1); r_conf[0] = mkconf(1, 0, 5, 0, 0);
    hs0 = hs_cnt; tc0 = err_cnt;
    pulse_kick();
    wait_done();
    check(err_cnt == tc0 + 1, "R4 flow error pulse", 32'(err_cnt - tc0), 1);
    check(hs_cnt == hs0, "R4 no access", 32'(hs_cnt - hs0), 0);

    // R7 R9: linked reload
    cur_req = "R7";
    clear_chans();
    mem[128] = 32'h70; mem[129] = 32'h1D0; mem[130] = 32'h0; mem[131] = mkctrl(1, 1, 1, 2, 2, 2);
    r_src[0] = 32'h60; r_dst[0] = 32'h1C0; r_lli[0] = 32'h200;
    r_ctrl[0] = mkctrl(0, 1, 1, 2, 2, 1); r_conf[0] = mkconf(1, 0, 0, 0, 0);
    exp_elem(32'h60, 3'd2, 32'h1C0, 3'd2);
    exp_rd(32'h200, 3'd2); exp_rd(32'h204, 3'd2); exp_rd(32'h20C, 3'd2); exp_rd(32'h208, 3'd2);
    exp_elem(32'h70, 3'd2, 32'h1D0, 3'd2);
    exp_elem(32'h74, 3'd2, 32'h1D4, 3'd2);
    tc0 = tc_cnt[0];
    pulse_kick();
    wait_done();
    check(r_lli[0] == 0 && r_src[0] == 32'h78, "R7 descriptor applied", r_src[0], 32'h78);
    check(r_conf[0][0] == 1'b0, "R8 chain end clears enable", r_conf[0], 0);
    check(tc_cnt[0] == tc0 + 2, "R9 tc on reload and end", 32'(tc_cnt[0] - tc0), 2);

    // R10: channel 0 drains before channel 1
    cur_req = "R10";
    clear_chans();
    r_src[0] = 32'h80; r_dst[0] = 32'h240; r_ctrl[0] = mkctrl(0, 1, 1, 2, 2, 2); r_conf[0] = mkconf(1, 0, 0, 0, 0);
    r_src[1] = 32'h90; r_dst[1] = 32'h260; r_ctrl[1] = mkctrl(0, 1, 1, 2, 2, 2); r_conf[1] = mkconf(1, 0, 0, 0, 0);
    exp_elem(32'h80, 3'd2, 32'h240, 3'd2); exp_elem(32'h84, 3'd2, 32'h244, 3'd2);
    exp_elem(32'h90, 3'd2, 32'h260, 3'd2); exp_elem(32'h94, 3'd2, 32'h264, 3'd2);
    pulse_kick();
    wait_done();

    // R11: long memory stalls
    cur_req = "R11";
    rdy_div = 9;
    clear_chans();
    r_src[2] = 32'hA0; r_dst[2] = 32'h2A0; r_ctrl[2] = mkctrl(0, 1, 1, 2, 2, 2); r_conf[2] = mkconf(1, 0, 0, 0, 0);
    exp_elem(32'hA0, 3'd2, 32'h2A0, 3'd2); exp_elem(32'hA4, 3'd2, 32'h2A4, 3'd2);
    pulse_kick();
    wait_done();
    rdy_div = 3;

    // R12: kick during a scan reaches a lower channel
    cur_req = "R12";
    clear_chans();
    r_src[1] = 32'hC0; r_dst[1] = 32'h300; r_ctrl[1] = mkctrl(0, 1, 1, 2, 2, 4); r_conf[1] = mkconf(1, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) exp_elem(32'hC0 + 32'(4*i), 3'd2, 32'h300 + 32'(4*i), 3'd2);
    exp_elem(32'hE0, 3'd2, 32'h340, 3'd2);
    hs0 = hs_cnt;
    pulse_kick();
    for (int i = 0; i < 200; i++) begin
      if (hs_cnt != hs0) break;
      @(negedge clk);
    end
    r_src[0] = 32'hE0; r_dst[0] = 32'h340; r_ctrl[0] = mkctrl(0, 1, 1, 2, 2, 1); r_conf[0] = mkconf(1, 0, 0, 0, 0);
    pulse_kick();
    wait_done();
    check(r_ctrl[0][11:0] == 0, "R12 rescan served channel 0", r_ctrl[0], 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule